// File: doc/BRIEF.md
# I2C Controller Command and Control Register

This block is the software-visible 16-bit control word of an I2C controller, together with the small amount of hardware that guards it. Software writes the whole word through a write port (data plus a one-cycle enable). The block keeps a set of plain configuration fields: clock-stretch point, clock-stretch enable and general-call response. It also keeps an acknowledge value and an abort bit, and it turns requests for a START or STOP condition into level outputs for the bus engine.

START and STOP requests cannot both be pending. A write that asks for both is dropped, and a request that arrives while the other one is pending is refused. A pending request clears itself when the bus engine reports that the condition has gone out on the bus, or that the engine's timeout expired first. A timeout on a pending request can raise a sticky interrupt flag. A separate strobe clears that flag.

Requests exist only while the controller is enabled and acting as master. The abort bit can be set by software only. While it is set, the acknowledge field is held at NACK and software cannot change it. Hardware clears the abort bit when the abort completes or when the module is disabled.

Top module: `i2c_ctl_reg`

## Requirements
- R1: After a synchronous active-low reset, the read value is 0x0000, and `start_req`, `stop_req` and `tmo_irq` are 0.
- R2: Bit 4 (stretch point), bit 8 (general-call enable) and bit 9 (stretch enable) take the written value on every write and read it back. Bits 0 to 3 and 10 to 14 always read as 0.
- R3: With the controller enabled and in master mode, writing 1 to bit 6 raises the START request and writing 1 to bit 7 raises the STOP request. Writing 0 to either bit does not cancel a pending request. Read bits 6 and 7 always equal `start_req` and `stop_req`.
- R4: A write with both bit 6 and bit 7 set leaves both requests at 0, including a request that was already pending. The other fields of that write are still applied.
- R5: Writing bit 6 = 1 while STOP is pending leaves START at 0. Writing bit 7 = 1 while START is pending leaves STOP at 0. The two requests are never both 1.
- R6: A `cond_done` pulse clears both requests in the next cycle. It takes priority over a request written in the same cycle.
- R7: While `mod_en` or `master_mode` is 0, both requests are 0 from the next cycle on, and writes to bits 6 and 7 have no effect.
- R8: A `tmo_expired` pulse clears both requests. If a request was pending, the controller was enabled in master mode and `tmo_irq_en` was 1, `tmo_irq` goes to 1 and stays there until a cycle with `tmo_irq_clr` = 1 and no new timeout event. A timeout event wins over a clear in the same cycle.
- R9: While the abort bit (bit 15) is 1, the acknowledge bit (bit 5, 1 = NACK) reads 1 from the next cycle on, and writes to it are ignored. After the abort clears, bit 5 keeps its value until software writes it.
- R10: Writing 1 to bit 15 sets the abort bit, and writing 0 does not clear it. An `abort_done` pulse or `mod_en` = 0 clears it, and that clear wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| mod_en | input | 1 | Controller enable |
| master_mode | input | 1 | 1 when the controller acts as bus master |
| cond_done | input | 1 | Pulse: the pending START or STOP was put on the bus |
| tmo_expired | input | 1 | Pulse: the bus engine's timeout expired |
| abort_done | input | 1 | Pulse: the abort sequence has completed |
| tmo_irq_en | input | 1 | Enables raising the timeout interrupt |
| tmo_irq_clr | input | 1 | Clears the timeout interrupt flag |
| rd_data | output | 16 | Current control word |
| start_req | output | 1 | START request level to the bus engine |
| stop_req | output | 1 | STOP request level to the bus engine |
| tmo_irq | output | 1 | Sticky timeout interrupt |

## Verification
Every state element of this block drives an output directly, so a wrong internal value shows up on `rd_data`, `start_req`, `stop_req` or `tmo_irq` one cycle after the faulty update. The bench compares every output on every cycle. The hard cases are ones where two events land on the same edge: a rejected request beside a pending one, a done or timeout pulse beside a write, a clear strobe beside a timeout, and a disable beside an abort set. In each of these a wrong priority shows as a single-cycle difference in a request level or in bit 5 or bit 15. The bench drives each of them on purpose.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int REG_W      = 16;
  localparam int B_STRS     = 4;
  localparam int B_ACK      = 5;
  localparam int B_START    = 6;
  localparam int B_STOP     = 7;
  localparam int B_GCALL    = 8;
  localparam int B_STREN    = 9;
  localparam int B_ABORT    = 15;

  localparam logic [REG_W-1:0] PLAIN_MASK =
    (REG_W'(1) << B_STRS) | (REG_W'(1) << B_GCALL) | (REG_W'(1) << B_STREN);

  // New level of one request given its own state, the other request and the write bit.
  function automatic logic req_next(input logic own_q, input logic other_q,
                                    input logic wr_bit);
    return own_q | (wr_bit & ~other_q);
  endfunction

  // Assemble the read word from the individual fields.
  function automatic logic [REG_W-1:0] compose_word(
      input logic [REG_W-1:0] plain, input logic ack, input logic start,
      input logic stop, input logic abort_b);
    logic [REG_W-1:0] w;
    w = plain & PLAIN_MASK;
    w[B_ACK]   = ack;
    w[B_START] = start;
    w[B_STOP]  = stop;
    w[B_ABORT] = abort_b;
    return w;
  endfunction
endpackage

// File: rtl/i2c_req_ctl.sv
module i2c_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic hw_clear,
  input  logic wr_en,
  input  logic wr_start,
  input  logic wr_stop,
  output logic start_q,
  output logic stop_q,
  output logic wr_conflict
);
  import i2c_ctl_pkg::*;

  logic start_d, stop_d;

  assign wr_conflict = wr_en & wr_start & wr_stop;

  always_comb begin
    start_d = start_q;
    stop_d  = stop_q;
    if (!allow || hw_clear) begin
      start_d = 1'b0;
      stop_d  = 1'b0;
    end else if (wr_conflict) begin
      start_d = 1'b0;
      stop_d  = 1'b0;
    end else if (wr_en) begin
      start_d = req_next(start_q, stop_q, wr_start);
      stop_d  = req_next(stop_q, start_q, wr_stop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      stop_q  <= stop_d;
    end
  end
endmodule

// File: rtl/i2c_abort_ctl.sv
module i2c_abort_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_en,
  input  logic abort_done,
  input  logic wr_en,
  input  logic wr_abort,
  input  logic wr_ack,
  output logic abort_q,
  output logic ack_q
);
  logic abort_clr;
  logic abort_set;

  assign abort_clr = ~mod_en | abort_done;
  assign abort_set = wr_en & wr_abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      if (abort_clr)      abort_q <= 1'b0;
      else if (abort_set) abort_q <= 1'b1;
      if (abort_q)        ack_q   <= 1'b1;
      else if (wr_en)     ack_q   <= wr_ack;
    end
  end
endmodule

// File: rtl/i2c_tmo_flag.sv
module i2c_tmo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end
endmodule

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        mod_en,
  input  logic        master_mode,
  input  logic        cond_done,
  input  logic        tmo_expired,
  input  logic        abort_done,
  input  logic        tmo_irq_en,
  input  logic        tmo_irq_clr,
  output logic [15:0] rd_data,
  output logic        start_req,
  output logic        stop_req,
  output logic        tmo_irq
);
  import i2c_ctl_pkg::*;

  logic [REG_W-1:0] plain_q;
  logic             ctrl_on;
  logic             req_pending;
  logic             hw_clear;
  logic             tmo_event;
  logic             wr_conflict;
  logic             start_q, stop_q, abort_q, ack_q;

  assign ctrl_on     = mod_en & master_mode;
  assign req_pending = start_q | stop_q;
  assign hw_clear    = cond_done | tmo_expired;
  assign tmo_event   = ctrl_on & tmo_expired & req_pending & tmo_irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n)     plain_q <= '0;
    else if (wr_en) plain_q <= wr_data & PLAIN_MASK;
  end

  i2c_req_ctl u_req (
    .clk(clk), .rst_n(rst_n), .allow(ctrl_on), .hw_clear(hw_clear),
    .wr_en(wr_en), .wr_start(wr_data[B_START]), .wr_stop(wr_data[B_STOP]),
    .start_q(start_q), .stop_q(stop_q), .wr_conflict(wr_conflict)
  );

  i2c_abort_ctl u_abort (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .abort_done(abort_done),
    .wr_en(wr_en), .wr_abort(wr_data[B_ABORT]), .wr_ack(wr_data[B_ACK]),
    .abort_q(abort_q), .ack_q(ack_q)
  );

  i2c_tmo_flag u_tmo (
    .clk(clk), .rst_n(rst_n), .set_evt(tmo_event), .clr(tmo_irq_clr),
    .flag_q(tmo_irq)
  );

  assign rd_data   = compose_word(plain_q, ack_q, start_q, stop_q, abort_q);
  assign start_req = start_q;
  assign stop_req  = stop_q;
endmodule

// File: rtl/i2c_ctl_reg_chk.sv
module i2c_ctl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mod_en,
  input logic        master_mode,
  input logic        cond_done,
  input logic        tmo_expired,
  input logic        abort_done,
  input logic        tmo_irq_clr,
  input logic        wr_conflict,
  input logic [15:0] rd_data,
  input logic        start_req,
  input logic        stop_req,
  input logic        tmo_irq
);
  a_r5_mutex: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_req && stop_req));

  a_r4_conflict_drops: assert property (@(posedge clk) disable iff (!rst_n)
    wr_conflict |=> (!start_req && !stop_req));

  a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cond_done |=> (!start_req && !stop_req));

  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_en && master_mode) |=> (!start_req && !stop_req));

  a_r8_tmo_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_expired |=> (!start_req && !stop_req));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_irq && !tmo_irq_clr) |=> tmo_irq);

  a_r9_nack_forced: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15] |=> rd_data[5]);

  a_r10_abort_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15] && mod_en && !abort_done) |=> rd_data[15]);

  a_r10_abort_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_en || abort_done) |=> !rd_data[15]);
endmodule

bind i2c_ctl_reg i2c_ctl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .master_mode(master_mode),
  .cond_done(cond_done), .tmo_expired(tmo_expired), .abort_done(abort_done),
  .tmo_irq_clr(tmo_irq_clr), .wr_conflict(wr_conflict), .rd_data(rd_data),
  .start_req(start_req), .stop_req(stop_req), .tmo_irq(tmo_irq)
);

// File: tb/tb_i2c_ctl_reg.sv
module tb_i2c_ctl_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic        mod_en = 1'b0;
  logic        master_mode = 1'b0;
  logic        cond_done = 1'b0;
  logic        tmo_expired = 1'b0;
  logic        abort_done = 1'b0;
  logic        tmo_irq_en = 1'b0;
  logic        tmo_irq_clr = 1'b0;
  logic [15:0] rd_data;
  logic        start_req, stop_req, tmo_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Behavioural reference state
  bit m_strs, m_ack, m_start, m_stop, m_gc, m_stren, m_abort, m_irq;

  always #5 clk = ~clk;

  i2c_ctl_reg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mod_en(mod_en), .master_mode(master_mode), .cond_done(cond_done),
    .tmo_expired(tmo_expired), .abort_done(abort_done),
    .tmo_irq_en(tmo_irq_en), .tmo_irq_clr(tmo_irq_clr),
    .rd_data(rd_data), .start_req(start_req), .stop_req(stop_req),
    .tmo_irq(tmo_irq)
  );

  always @(posedge clk) begin
    bit o_start, o_stop, o_abort, on, ws, wp;
    o_start = m_start; o_stop = m_stop; o_abort = m_abort;
    on = mod_en && master_mode;
    ws = wr_data[6]; wp = wr_data[7];
    if (!rst_n) begin
      {m_strs, m_ack, m_start, m_stop, m_gc, m_stren, m_abort, m_irq} = '0;
    end else begin
      if (wr_en) begin
        m_strs = wr_data[4]; m_gc = wr_data[8]; m_stren = wr_data[9];
      end
      if (!on || cond_done || tmo_expired) begin
        m_start = 0; m_stop = 0;
      end else if (wr_en) begin
        if (ws && wp) begin
          m_start = 0; m_stop = 0;
        end else begin
          if (ws && !o_stop) m_start = 1;
          if (wp && !o_start) m_stop = 1;
        end
      end
      if (on && tmo_expired && (o_start || o_stop) && tmo_irq_en) m_irq = 1;
      else if (tmo_irq_clr) m_irq = 0;
      if (!mod_en || abort_done) m_abort = 0;
      else if (wr_en && wr_data[15]) m_abort = 1;
      if (o_abort) m_ack = 1;
      else if (wr_en) m_ack = wr_data[5];
    end
  end

  function automatic logic [15:0] model_word();
    logic [15:0] w;
    w = '0;
    w[4] = m_strs; w[5] = m_ack; w[6] = m_start; w[7] = m_stop;
    w[8] = m_gc; w[9] = m_stren; w[15] = m_abort;
    return w;
  endfunction

  task automatic compare(input string tag);
    n_cmp++;
    if (rd_data !== model_word() || start_req !== m_start ||
        stop_req !== m_stop || tmo_irq !== m_irq) begin
      n_bad++;
      $display("FAIL %s: rd=%h start=%b stop=%b irq=%b expected rd=%h start=%b stop=%b irq=%b",
               tag, rd_data, start_req, stop_req, tmo_irq,
               model_word(), m_start, m_stop, m_irq);
    end
  endtask

  task automatic check_val(input string tag, input logic [15:0] act,
                           input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: inputs already set; compare after the edge, then drop pulses.
  task automatic tick(input string tag);
    @(negedge clk);
    compare(tag);
    wr_en = 0; cond_done = 0; tmo_expired = 0; abort_done = 0; tmo_irq_clr = 0;
  endtask

  task automatic wr(input logic [15:0] d, input string tag);
    wr_en = 1; wr_data = d;
    tick(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_val("R1 reset word", rd_data, 16'h0000);
    check_val("R1 reset outputs", {13'h0, start_req, stop_req, tmo_irq}, 16'h0);
    compare("R1");

    mod_en = 1; master_mode = 1;
    tick("R1 idle");

    // R2: plain fields and reserved bits
    wr(16'h7F3F, "R2 fields");
    check_val("R2 readback", rd_data, 16'h0330);
    wr(16'h0000, "R2 clear");
    check_val("R2 zero", rd_data, 16'h0000);

    // R3: requests and non-cancelling zero writes
    wr(16'h0040, "R3 start");
    check_val("R3 start level", {15'h0, start_req}, 16'h1);
    wr(16'h0000, "R3 zero keeps");
    check_val("R3 start kept", rd_data, 16'h0040);
    cond_done = 1; tick("R3 done");
    wr(16'h0080, "R3 stop");
    check_val("R3 stop bit", rd_data, 16'h0080);
    cond_done = 1; tick("R6 done stop");

    // R5: cross rejection
    wr(16'h0040, "R5 start");
    wr(16'h0080, "R5 stop refused");
    check_val("R5 stop stays 0", {15'h0, stop_req}, 16'h0);
    cond_done = 1; tick("R5 done");
    wr(16'h0080, "R5 stop");
    wr(16'h0140, "R5 start refused");
    check_val("R5 start stays 0, gcall applied", rd_data, 16'h0180);
    cond_done = 1; tick("R5 done2");

    // R4: both in one write
    wr(16'h03C0, "R4 both");
    check_val("R4 dropped, fields applied", rd_data, 16'h0300);
    wr(16'h0080, "R4 stop pending");
    wr(16'h00C0, "R4 both with pending");
    check_val("R4 pending dropped", rd_data, 16'h0000);

    // R6: done beats a same-cycle write
    wr(16'h0040, "R6 start");
    cond_done = 1; wr(16'h0040, "R6 done with write");
    check_val("R6 cleared", {15'h0, start_req}, 16'h0);
    cond_done = 1; wr(16'h0080, "R6 done with stop write");

    // R7: gating by master mode and enable
    wr(16'h0040, "R7 start");
    master_mode = 0; tick("R7 master off");
    check_val("R7 dropped", {15'h0, start_req}, 16'h0);
    wr(16'h0080, "R7 write ignored");
    check_val("R7 stop ignored", {15'h0, stop_req}, 16'h0);
    master_mode = 1; wr(16'h0080, "R7 stop");
    mod_en = 0; tick("R7 enable off");
    wr(16'h0040, "R7 write ignored off");
    check_val("R7 start ignored", {15'h0, start_req}, 16'h0);
    mod_en = 1; tick("R7 back");

    // R8: timeout and sticky interrupt
    tmo_irq_en = 1;
    wr(16'h0040, "R8 start");
    tmo_expired = 1; tick("R8 timeout");
    check_val("R8 irq set, req clear", {14'h0, start_req, tmo_irq}, 16'h1);
    repeat (3) tick("R8 sticky");
    tmo_irq_clr = 1; tick("R8 clear");
    check_val("R8 irq cleared", {15'h0, tmo_irq}, 16'h0);
    wr(16'h0080, "R8 stop");
    tmo_expired = 1; tmo_irq_clr = 1; tick("R8 set wins");
    check_val("R8 set beats clear", {15'h0, tmo_irq}, 16'h1);
    tmo_irq_clr = 1; tick("R8 clear2");
    tmo_expired = 1; tick("R8 no pending");
    check_val("R8 no event without request", {15'h0, tmo_irq}, 16'h0);
    tmo_irq_en = 0;
    wr(16'h0040, "R8 start no irq");
    tmo_expired = 1; tick("R8 disabled irq");
    check_val("R8 irq disabled", {15'h0, tmo_irq}, 16'h0);

    // R9 / R10: abort and acknowledge lock
    wr(16'h8000, "R10 set abort");
    check_val("R10 abort set, ack 0", rd_data, 16'h8000);
    tick("R9 forced");
    check_val("R9 ack forced", rd_data, 16'h8020);
    wr(16'h0000, "R9 write ignored");
    check_val("R10 zero keeps abort, R9 ack kept", rd_data, 16'h8020);
    abort_done = 1; tick("R10 done");
    check_val("R10 cleared, ack kept", rd_data, 16'h0020);
    wr(16'h0000, "R9 ack writable");
    check_val("R9 ack 0", rd_data, 16'h0000);
    wr(16'h8000, "R10 set again");
    mod_en = 0; tick("R10 disable");
    check_val("R10 disabled clears", {15'h0, rd_data[15]}, 16'h0);
    wr(16'h8000, "R10 set while off");
    mod_en = 1;
    abort_done = 1; wr(16'h8020, "R10 clear wins");
    check_val("R10 clear beats set", {15'h0, rd_data[15]}, 16'h0);
    repeat (2) tick("R9 idle");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule